// File: doc/BRIEF.md
# Four-Channel Edge Capture Unit with Buffer Chaining

This block watches four asynchronous input pins and, on a chosen transition of each, stores the value of a 16-bit running count in a capture register for that channel. Each capture also raises a sticky flag. The count is supplied from outside on `countIn`. The block does not hold or advance the counter itself.

Channels C and D can be paired as history buffers behind channels A and B. When a pairing is enabled, every capture on the primary channel also moves that channel's previous value into its partner. Each capture therefore keeps the two most recent timestamps. In this mode the partner pin is ignored. The partner's edge-select bit then does a second job. If it differs from the primary's select bit, the primary channel captures on both edges. This allows pulse widths to be measured from one pin.

Top module: `quadCaptureUnit`

## Requirements
- R1: After reset, all four capture registers read 0x0000 and all four flags read 0.
- R2: On the selected transition of an unbuffered channel's pin, the register is loaded with `countIn`. The flag is set on the third rising clock edge after the pin change is sampled. `edgeSel` bit value 1 selects a rising transition and 0 selects a falling one.
- R3: The transition opposite to the selected one leaves an unbuffered channel's register and flag unchanged.
- R4: A new capture overwrites the register even when that channel's flag is already 1.
- R5: With `bufEn[0]`=1, a capture on A loads `countIn` into A and loads A's previous value into C. `bufEn[1]` does the same for B into D.
- R6: With a pairing enabled and the two select bits of the pair differing, the primary channel captures on both rising and falling transitions.
- R7: With a pairing enabled and equal select bits in the pair, the primary channel captures only on the transition its select bit names.
- R8: With a pairing enabled, transitions on the partner pin (C or D) change neither the partner's register nor its flag.
- R9: A pulse on `flagWrZero[i]` clears flag i only if, since the last write, a pulse on `flagRead[i]` occurred while flag i was 1. Otherwise the flag stays set.
- R10: When a capture and a valid clear land in the same cycle, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| countIn | input | 16 | Running count value to be captured |
| capPin | input | 4 | Asynchronous capture pins, bit 0 = A ... bit 3 = D |
| edgeSel | input | 4 | Per-channel transition select, 1 = rising, 0 = falling |
| bufEn | input | 2 | Bit 0 chains C behind A, bit 1 chains D behind B |
| flagRead | input | 4 | Per-channel strobe marking a read of the flag |
| flagWrZero | input | 4 | Per-channel strobe writing 0 to the flag |
| capValA | output | 16 | Capture register A |
| capValB | output | 16 | Capture register B |
| capValC | output | 16 | Capture register C |
| capValD | output | 16 | Capture register D |
| capFlag | output | 4 | Capture flags, bit order as capPin |

## Verification
Two functions can land in one clock: a capture that sets a flag, and a software clear of that same flag. The bench arms the clear by reading the flag while it is 1. It then drives the write-zero strobe in exactly the cycle in which the synchronized edge loads the register, by counting the two synchronizer stages. The flag is judged to have stayed 1, and the register to hold the new count. A second overlap, a primary capture that shifts into the partner at the same moment, is checked by reading both registers after a pair of captures.

// File: rtl/capPkg.sv
package capPkg;
  localparam int NumCh   = 4;
  localparam int NumPair = NumCh / 2;

  typedef struct packed {
    logic [NumCh-1:0]   load;   // register i takes countIn
    logic [NumPair-1:0] shift;  // partner p+2 takes old value of p
  } capStrobeT;
endpackage

// File: rtl/capCtrl.sv
module capCtrl
  import capPkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NumCh-1:0] capPin,
  input  logic [NumCh-1:0] edgeSel,
  input  logic [NumPair-1:0] bufEn,
  input  logic [NumCh-1:0] flagRead,
  input  logic [NumCh-1:0] flagWrZero,
  output capStrobeT        strobe,
  output logic [NumCh-1:0] capFlag
);
  logic [SyncStages-1:0] syncQ [NumCh];
  logic [NumCh-1:0] synced, lastQ, riseEv, fallEv, selEv, trig, armed, clrTry;

  for (genvar ch = 0; ch < NumCh; ch++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[ch] <= '0;
      else       syncQ[ch] <= {syncQ[ch][SyncStages-2:0], capPin[ch]};
    end
    assign synced[ch] = syncQ[ch][SyncStages-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lastQ <= '0;
    else       lastQ <= synced;
  end

  assign riseEv = synced & ~lastQ;
  assign fallEv = ~synced & lastQ;

  always_comb begin
    for (int i = 0; i < NumCh; i++)
      selEv[i] = edgeSel[i] ? riseEv[i] : fallEv[i];
  end

  for (genvar p = 0; p < NumPair; p++) begin : gPair
    logic dualEdge;
    assign dualEdge     = bufEn[p] && (edgeSel[p] != edgeSel[p+NumPair]);
    assign trig[p]      = dualEdge ? (riseEv[p] | fallEv[p]) : selEv[p];
    assign trig[p+NumPair] = bufEn[p] ? 1'b0 : selEv[p+NumPair];

    // R8: a chained partner never gains a flag from its own pin
    assert_partner_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
      (bufEn[p] && !capFlag[p+NumPair]) |=> !capFlag[p+NumPair]);
  end

  assign strobe.load  = trig;
  assign strobe.shift = bufEn & trig[NumPair-1:0];

  assign clrTry = flagWrZero & armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capFlag <= '0;
      armed   <= '0;
    end else begin
      capFlag <= trig | (capFlag & ~clrTry);
      for (int i = 0; i < NumCh; i++) begin
        if (flagWrZero[i])                    armed[i] <= 1'b0;
        else if (flagRead[i] && capFlag[i])   armed[i] <= 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NumCh; i++) begin : gFlagChk
    // R2 and R10: a capture always leaves the flag set, even if a clear collides
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rstN)
      strobe.load[i] |=> capFlag[i]);
    // R9: a flag only falls after an armed write of zero
    assert_clear_armed_R9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(capFlag[i]) |-> $past(flagWrZero[i] && armed[i]));
  end
endmodule

// File: rtl/capData.sv
module capData
  import capPkg::*;
#(
  parameter int CountW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CountW-1:0] countIn,
  input  capStrobeT         strobe,
  output logic [CountW-1:0] capVal [NumCh]
);
  for (genvar i = 0; i < NumCh; i++) begin : gReg
    if (i < NumPair) begin : gPrimary
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               capVal[i] <= '0;
        else if (strobe.load[i]) capVal[i] <= countIn;
      end
    end else begin : gPartner
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        capVal[i] <= '0;
        else if (strobe.load[i])          capVal[i] <= countIn;
        else if (strobe.shift[i-NumPair]) capVal[i] <= capVal[i-NumPair];
      end
    end

    // R2/R4: a load takes the count regardless of prior content
    assert_load_count_R4: assert property (@(posedge clk) disable iff (!rstN)
      strobe.load[i] |=> capVal[i] == $past(countIn));
  end

  for (genvar p = 0; p < NumPair; p++) begin : gShiftChk
    // R5: the partner receives the primary's previous value
    assert_shift_chain_R5: assert property (@(posedge clk) disable iff (!rstN)
      strobe.shift[p] |=> capVal[p+NumPair] == $past(capVal[p]));
    // R3: with no load or shift, the partner is held
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.load[p+NumPair] && !strobe.shift[p]) |=> $stable(capVal[p+NumPair]));
  end
endmodule

// File: rtl/quadCaptureUnit.sv
module quadCaptureUnit
  import capPkg::*;
#(
  parameter int CountW     = 16,
  parameter int SyncStages = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CountW-1:0] countIn,
  input  logic [3:0]        capPin,
  input  logic [3:0]        edgeSel,
  input  logic [1:0]        bufEn,
  input  logic [3:0]        flagRead,
  input  logic [3:0]        flagWrZero,
  output logic [CountW-1:0] capValA,
  output logic [CountW-1:0] capValB,
  output logic [CountW-1:0] capValC,
  output logic [CountW-1:0] capValD,
  output logic [3:0]        capFlag
);
  capStrobeT         strobe;
  logic [CountW-1:0] capVal [NumCh];

  capCtrl #(.SyncStages(SyncStages)) i_capCtrl (
    .clk(clk), .rstN(rstN), .capPin(capPin), .edgeSel(edgeSel),
    .bufEn(bufEn), .flagRead(flagRead), .flagWrZero(flagWrZero),
    .strobe(strobe), .capFlag(capFlag)
  );

  capData #(.CountW(CountW)) i_capData (
    .clk(clk), .rstN(rstN), .countIn(countIn), .strobe(strobe), .capVal(capVal)
  );

  assign capValA = capVal[0];
  assign capValB = capVal[1];
  assign capValC = capVal[2];
  assign capValD = capVal[3];
endmodule

// File: tb/test_quadCaptureUnit.sv
module test_quadCaptureUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] countIn = '0;
  logic [3:0]  capPin = '0, edgeSel = '0, flagRead = '0, flagWrZero = '0;
  logic [1:0]  bufEn = '0;
  logic [15:0] capValA, capValB, capValC, capValD;
  logic [3:0]  capFlag;
  int vecCnt = 0, errCnt = 0;

  always #4 clk = ~clk;

  quadCaptureUnit i_quadCaptureUnit (
    .clk(clk), .rstN(rstN), .countIn(countIn), .capPin(capPin), .edgeSel(edgeSel),
    .bufEn(bufEn), .flagRead(flagRead), .flagWrZero(flagWrZero),
    .capValA(capValA), .capValB(capValB), .capValC(capValC), .capValD(capValD),
    .capFlag(capFlag)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; capPin = '0; edgeSel = '0; bufEn = '0;
    flagRead = '0; flagWrZero = '0; countIn = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // change one pin, wait for synchronizer + edge register + load, sample at negedge
  task automatic setPin(input int ch, input logic val, input logic [15:0] cnt);
    @(negedge clk);
    countIn = cnt;
    capPin[ch] = val;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readFlag(input int ch);
    @(negedge clk); flagRead[ch] = 1'b1;
    @(negedge clk); flagRead[ch] = 1'b0;
  endtask

  task automatic writeZero(input int ch);
    @(negedge clk); flagWrZero[ch] = 1'b1;
    @(negedge clk); flagWrZero[ch] = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 capA", capValA, 16'h0); check("R1 capB", capValB, 16'h0);
    check("R1 capC", capValC, 16'h0); check("R1 capD", capValD, 16'h0);
    check("R1 flags", {12'h0, capFlag}, 16'h0);
  endtask

  task automatic testSingleEdge();
    doReset();
    edgeSel = 4'b0101; // A,C rising; B,D falling
    setPin(0, 1'b1, 16'h1234);
    check("R2 capA rise", capValA, 16'h1234);
    check("R2 flagA", {15'h0, capFlag[0]}, 16'h1);
    setPin(0, 1'b0, 16'h5555);
    check("R3 capA on fall", capValA, 16'h1234);
    setPin(1, 1'b1, 16'h2222);
    check("R3 capB on rise", capValB, 16'h0);
    check("R3 flagB", {15'h0, capFlag[1]}, 16'h0);
    setPin(1, 1'b0, 16'h3333);
    check("R2 capB fall", capValB, 16'h3333);
    setPin(2, 1'b1, 16'h4444);
    check("R2 capC rise", capValC, 16'h4444);
  endtask

  task automatic testOverwrite();
    doReset();
    edgeSel = 4'b1111;
    setPin(3, 1'b1, 16'h0A0A);
    setPin(3, 1'b0, 16'h0000);
    setPin(3, 1'b1, 16'hBEEF);
    check("R4 capD overwrite", capValD, 16'hBEEF);
    check("R4 flagD", {15'h0, capFlag[3]}, 16'h1);
  endtask

  task automatic testChain();
    doReset();
    edgeSel = 4'b1111; bufEn = 2'b11;
    setPin(0, 1'b1, 16'h0011);
    setPin(0, 1'b0, 16'h0099);
    check("R7 no fall capture A", capValA, 16'h0011);
    setPin(0, 1'b1, 16'h0022);
    check("R5 capA new", capValA, 16'h0022);
    check("R5 capC old", capValC, 16'h0011);
    setPin(1, 1'b1, 16'h7001);
    setPin(1, 1'b0, 16'h0000);
    setPin(1, 1'b1, 16'h7002);
    check("R5 capB new", capValB, 16'h7002);
    check("R5 capD old", capValD, 16'h7001);
    setPin(2, 1'b1, 16'hDEAD);
    setPin(2, 1'b0, 16'hDEAD);
    check("R8 capC held", capValC, 16'h0011);
    check("R8 flagC", {15'h0, capFlag[2]}, 16'h0);
  endtask

  task automatic testDualEdge();
    doReset();
    edgeSel = 4'b0001; bufEn = 2'b01;
    setPin(0, 1'b1, 16'h0100);
    check("R6 rise capA", capValA, 16'h0100);
    setPin(0, 1'b0, 16'h0200);
    check("R6 fall capA", capValA, 16'h0200);
    check("R6 capC", capValC, 16'h0100);
  endtask

  task automatic testFlagClear();
    doReset();
    edgeSel = 4'b1111;
    setPin(1, 1'b1, 16'h0001);
    writeZero(1);
    check("R9 clear without read", {15'h0, capFlag[1]}, 16'h1);
    readFlag(1);
    writeZero(1);
    check("R9 clear after read", {15'h0, capFlag[1]}, 16'h0);
  endtask

  task automatic testCollision();
    doReset();
    edgeSel = 4'b1111;
    setPin(0, 1'b1, 16'h0AAA);
    setPin(0, 1'b0, 16'h0000);
    readFlag(0);
    @(negedge clk);
    countIn = 16'h0BBB;
    capPin[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); flagWrZero[0] = 1'b1;
    @(negedge clk); flagWrZero[0] = 1'b0;
    check("R10 flag survives", {15'h0, capFlag[0]}, 16'h1);
    check("R10 capA", capValA, 16'h0BBB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    testReset();
    testSingleEdge();
    testOverwrite();
    testChain();
    testDualEdge();
    testFlagClear();
    testCollision();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule